// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped master for Clause 45 extended management access to Ethernet PHYs. Software loads a 16-bit target register number into an address register, then writes a command word holding the port address, device address, a 3-bit command code and, for writes, 16 bits of data. The block answers with two serial frames on the management pins. The first frame sets the register address. The second frame either writes the data or reads a value back from the PHY.

The MDC clock runs only while a command is in progress. One MDC period is `2*HALF` system clocks. The block changes its output while MDC is low, and it samples read data on the rising MDC edge. Software polls a busy flag in the command register. After a read, it takes the data from the low half of that register once a valid flag is set.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, both registers read as zero, MDC is low and the MDIO output enable is low.
- R2: Offset 0x8 is the register-address register. Bits 15:0 are writable and bits 31:16 read as zero. A write to any offset other than 0x0 or 0x8 changes no register.
- R3: A write to offset 0x0 with command code 5 (write) or 7 (read) in bits 28:26, made while the block is idle, sets busy (bit 30) from the next clock. Busy then lasts exactly 2*(PRE+32)*2*HALF clocks, which covers exactly two frames. Any other command code has no effect.
- R4: Each frame is PRE ones, then start 00, a 2-bit op, the 5-bit port address, the 5-bit device address, a 2-bit turnaround and 16 data bits. Every field is sent MSB first, one bit per MDC period, and MDIO changes only while MDC is low.
- R5: The first frame of every command has op 00 and turnaround 10. Its data field is the register-address register.
- R6: For a write command, the second frame has op 01 and turnaround 10. Its data field is bits 15:0 of the command word.
- R7: For a read command, the second frame has op 11. The output enable goes low for the turnaround and the 16 data bits. MDIO input is sampled on each rising MDC edge of the data bits. When the command ends, bit 29 (read valid) is set and bits 15:0 hold the received value, MSB first.
- R8: Read valid is cleared when a new command starts. A write command leaves it clear.
- R9: While busy, writes to either register are ignored: the address, the fields and the frames already in progress are unchanged.
- R10: Offset 0x0 reads back the port address in bits 20:16, the device address in bits 25:21 and the command code in bits 28:26 of the last accepted command.
- R11: When no command is in progress, MDC stays low and the MDIO output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench goes after the turnaround of a read. A design that released the line one bit late, or drove through the data field, would show a wrong enable pattern against the expected frame. It checks that read valid drops as soon as the next command starts; a design that kept it would let software take stale data. It writes both registers during a command and sends invalid command codes. A design that accepted these would emit an extra frame or corrupt the address. It also times busy to the exact clock and uses data patterns at both ends of the range (all zeros, all ones, a single edge bit), which expose an off-by-one in the bit index or a reversed shift.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  // frame op codes on the wire
  localparam logic [1:0] FOP_ADDR  = 2'b00;
  localparam logic [1:0] FOP_WRITE = 2'b01;
  localparam logic [1:0] FOP_READ  = 2'b11;

  // command codes in the command register
  localparam logic [2:0] CMD_WRITE = 3'd5;
  localparam logic [2:0] CMD_READ  = 3'd7;

  // register offsets
  localparam int OFS_CMD  = 0;
  localparam int OFS_ADDR = 8;

  // command register field positions
  localparam int F_PRT  = 16;
  localparam int F_DEV  = 21;
  localparam int F_OP   = 26;
  localparam int F_RV   = 29;
  localparam int F_BUSY = 30;

  // frame body after the preamble
  localparam int BODY_W  = 32;
  localparam int BODY_TA = 14;  // body bits before turnaround
  localparam int BODY_DT = 16;  // body bits before data

  function automatic logic [BODY_W-1:0] frame_body(
    input logic [1:0]  op,
    input logic [4:0]  prt,
    input logic [4:0]  dev,
    input logic [15:0] data
  );
    return {2'b00, op, prt, dev, 2'b10, data};
  endfunction

  function automatic logic cmd_ok(input logic [2:0] code);
    return (code == CMD_WRITE) || (code == CMD_READ);
  endfunction

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic slot_end,
  output logic sample
);
  localparam int SLOT = 2 * HALF;
  localparam int CW   = (SLOT > 2) ? $clog2(SLOT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!run)                    cnt_q <= '0;
    else if (cnt_q == CW'(SLOT - 1))  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign mdc      = run && (cnt_q >= CW'(HALF));
  assign slot_end = run && (cnt_q == CW'(SLOT - 1));
  assign sample   = run && (cnt_q == CW'(HALF));

  // R4: a slot closes only after MDC has been high
  p_slot_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> mdc);

endmodule

// File: rtl/mdio_c45_engine.sv
module mdio_c45_engine
  import mdio_c45_pkg::*;
#(
  parameter int PRE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_read,
  input  logic [4:0]  prt,
  input  logic [4:0]  dev,
  input  logic [15:0] reg_num,
  input  logic [15:0] wr_data,
  input  logic        slot_end,
  input  logic        sample,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int FLEN = PRE + BODY_W;
  localparam int IW   = $clog2(FLEN);

  logic          busy_q, phase_q;
  logic [IW-1:0] idx_q;
  logic [15:0]   sh_q;

  wire last_bit = slot_end && (idx_q == IW'(FLEN - 1));
  wire in_pre   = idx_q < IW'(PRE);
  wire rd_phase = phase_q && is_read;
  wire released = rd_phase && (idx_q >= IW'(PRE + BODY_TA));
  wire in_data  = idx_q >= IW'(PRE + BODY_DT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else if (busy_q) begin
      if (sample && rd_phase && in_data)
        sh_q <= {sh_q[14:0], mdio_i};
      if (last_bit) begin
        idx_q <= '0;
        if (phase_q) busy_q  <= 1'b0;
        else         phase_q <= 1'b1;
      end else if (slot_end) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  logic [1:0]        fop;
  logic [BODY_W-1:0] body;
  logic [4:0]        bpos;

  always_comb begin
    if (!phase_q)    fop = FOP_ADDR;
    else if (is_read) fop = FOP_READ;
    else             fop = FOP_WRITE;
    body = frame_body(fop, prt, dev, phase_q ? wr_data : reg_num);
    bpos = 5'(IW'(FLEN - 1) - idx_q);
  end

  assign busy    = busy_q;
  assign done    = busy_q && phase_q && last_bit;
  assign rd_data = sh_q;
  assign mdio_oe = busy_q && !released;
  assign mdio_o  = busy_q && !released && (in_pre || body[bpos]);

  // R3: a second frame always follows the first before busy drops
  p_two_frames_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !phase_q) |=> busy_q);

endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
  import mdio_c45_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [15:0]   rd_data_i,
  output logic          start,
  output logic          is_read,
  output logic [4:0]    prt,
  output logic [4:0]    dev,
  output logic [15:0]   reg_num,
  output logic [15:0]   wr_data
);
  logic [15:0] areg_q, data_q;
  logic [4:0]  prt_q, dev_q;
  logic [2:0]  op_q;
  logic        rv_q;

  wire hit_cmd  = wr && (addr == AW'(OFS_CMD));
  wire hit_addr = wr && (addr == AW'(OFS_ADDR));
  wire [2:0] new_op = wdata[F_OP +: 3];

  assign start = hit_cmd && !busy_i && cmd_ok(new_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      areg_q <= '0;
      data_q <= '0;
      prt_q  <= '0;
      dev_q  <= '0;
      op_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      if (hit_addr && !busy_i) areg_q <= wdata[15:0];
      if (start) begin
        prt_q  <= wdata[F_PRT +: 5];
        dev_q  <= wdata[F_DEV +: 5];
        op_q   <= new_op;
        rv_q   <= 1'b0;
        data_q <= (new_op == CMD_WRITE) ? wdata[15:0] : 16'h0000;
      end
      if (done_i && (op_q == CMD_READ)) begin
        rv_q   <= 1'b1;
        data_q <= rd_data_i;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_CMD)) begin
      rdata[15:0]        = data_q;
      rdata[F_PRT +: 5]  = prt_q;
      rdata[F_DEV +: 5]  = dev_q;
      rdata[F_OP +: 3]   = op_q;
      rdata[F_RV]        = rv_q;
      rdata[F_BUSY]      = busy_i;
    end else if (addr == AW'(OFS_ADDR)) begin
      rdata[15:0] = areg_q;
    end
  end

  logic unused_hi;
  assign unused_hi = ^wdata[31:29];

  assign is_read = (op_q == CMD_READ);
  assign prt     = prt_q;
  assign dev     = dev_q;
  assign reg_num = areg_q;
  assign wr_data = data_q;

  // R8: valid is clear whenever a command has just begun
  p_rv_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> !rv_q);

  // R9: the address register cannot move during a command
  p_addr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(areg_q));

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int AW   = 4,
  parameter int HALF = 4,
  parameter int PRE  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  // named internal events
  logic        start_evt, done_evt, slot_end_evt, sample_evt;
  logic        eng_busy, cmd_is_read;
  logic [4:0]  f_prt, f_dev;
  logic [15:0] f_reg, f_wdat, f_rdat;

  mdio_c45_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy_i    (eng_busy),
    .done_i    (done_evt),
    .rd_data_i (f_rdat),
    .start     (start_evt),
    .is_read   (cmd_is_read),
    .prt       (f_prt),
    .dev       (f_dev),
    .reg_num   (f_reg),
    .wr_data   (f_wdat)
  );

  mdio_c45_clkgen #(.HALF(HALF)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (eng_busy),
    .mdc      (mdc),
    .slot_end (slot_end_evt),
    .sample   (sample_evt)
  );

  mdio_c45_engine #(.PRE(PRE)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .is_read  (cmd_is_read),
    .prt      (f_prt),
    .dev      (f_dev),
    .reg_num  (f_reg),
    .wr_data  (f_wdat),
    .slot_end (slot_end_evt),
    .sample   (sample_evt),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .done     (done_evt),
    .rd_data  (f_rdat),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  // R3: an accepted command shows busy on the next clock
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> eng_busy);

  // R11: no clock toggling while idle
  p_mdc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !mdc);

  // R4: data holds while MDC is high
  p_mdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R7: the line is released only for a read command
  p_release_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !mdio_oe) |-> cmd_is_read);

endmodule

// File: tb/mdio_c45_master_test.sv
module mdio_c45_master_test;
  localparam int CLK_PER = 10;
  localparam int HALF    = 4;
  localparam int PRE     = 32;
  localparam int FLEN    = PRE + 32;
  localparam int DUR     = 2 * FLEN * 2 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_c45_master #(.AW(4), .HALF(HALF), .PRE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PER/2) clk = ~clk;

  typedef struct {
    logic [63:0] v;
    logic [63:0] m;
    logic [63:0] oe;
    logic [15:0] phy;
    bit          rd;
    int          kind;  // 0 address, 1 write, 2 read
  } frame_t;

  frame_t q[$];
  frame_t e;
  int errs = 0;
  int checks = 0;
  int bitn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: collects each frame and compares with the scoreboard
  initial begin : monitor
    logic [63:0] cv, co;
    cv = '0; co = '0;
    forever begin
      @(posedge mdc);
      cv = {cv[62:0], mdio_o};
      co = {co[62:0], mdio_oe};
      bitn++;
      if (bitn == FLEN) begin
        bitn = 0;
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected frame", cv, 64'h0);
        end else begin
          e = q.pop_front();
          case (e.kind)
            0: begin
              chk(((cv ^ e.v) & e.m) == 0, "R5", "address frame bits", cv, e.v);
              chk(co == e.oe, "R4", "address frame enable", co, e.oe);
            end
            1: begin
              chk(((cv ^ e.v) & e.m) == 0, "R6", "write frame bits", cv, e.v);
              chk(co == e.oe, "R6", "write frame enable", co, e.oe);
            end
            default: begin
              chk(((cv ^ e.v) & e.m) == 0, "R7", "read frame header", cv, e.v);
              chk(co == e.oe, "R7", "read frame release", co, e.oe);
            end
          endcase
        end
      end
    end
  end

  // PHY model: drives read data after MDC falls
  initial begin : phy
    forever begin
      @(negedge mdc);
      if (q.size() > 0 && q[0].rd && bitn >= 48) mdio_i <= q[0].phy[63 - bitn];
      else                                      mdio_i <= 1'b1;
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 32'h0;
    #1;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 4'h0;
  endtask

  function automatic logic [31:0] cmd_word(input logic [2:0] op, input logic [4:0] p,
                                           input logic [4:0] dv, input logic [15:0] d);
    return (32'(op) << 26) | (32'(dv) << 21) | (32'(p) << 16) | 32'(d);
  endfunction

  // driver: loads the address, pushes the expected frames, issues the command
  task automatic issue(input logic [2:0] op, input logic [4:0] p, input logic [4:0] dv,
                       input logic [15:0] adr, input logic [15:0] d, input logic [15:0] phyv);
    frame_t f;
    bus_write(4'h8, {16'h0, adr});
    f.v = {32'hFFFF_FFFF, 2'b00, 2'b00, p, dv, 2'b10, adr};
    f.m = '1; f.oe = '1; f.phy = '0; f.rd = 1'b0; f.kind = 0;
    q.push_back(f);
    if (op == 3'd5) begin
      f.v = {32'hFFFF_FFFF, 2'b00, 2'b01, p, dv, 2'b10, d};
      f.kind = 1;
    end else begin
      f.v = {32'hFFFF_FFFF, 2'b00, 2'b11, p, dv, 2'b00, 16'h0};
      f.m = {{46{1'b1}}, 18'h0};
      f.oe = {{46{1'b1}}, 18'h0};
      f.phy = phyv; f.rd = 1'b1; f.kind = 2;
    end
    q.push_back(f);
    bus_write(4'h0, cmd_word(op, p, dv, d));
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    reg_addr = 4'h0;
    #1;
    while (reg_rdata[30]) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_read(4'h0, r); chk(r == 0, "R1", "command reg after reset", r, 0);
    bus_read(4'h8, r); chk(r == 0, "R1", "address reg after reset", r, 0);
    chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);

    // R2 address register width and unmapped offset
    bus_write(4'h8, 32'hFFFF_1234);
    bus_read(4'h8, r); chk(r == 32'h0000_1234, "R2", "address readback", r, 32'h1234);
    bus_write(4'h4, 32'h0000_5555);
    bus_read(4'h8, r); chk(r == 32'h0000_1234, "R2", "unmapped write kept address", r, 32'h1234);
    bus_read(4'h0, r); chk(r == 0, "R2", "unmapped write kept command", r, 0);

    // R3 R6 write command, exact busy window
    issue(3'd5, 5'h15, 5'h07, 16'hA5C3, 16'h3C5A, 16'h0);
    wait_idle(cyc);
    chk(cyc == DUR, "R3", "busy duration write", cyc, DUR);
    chk(q.size() == 0, "R3", "both frames seen", q.size(), 0);
    chk(!mdc && !mdio_oe, "R11", "idle pins after command", {mdc, mdio_oe}, 0);
    bus_read(4'h0, r);
    chk(r[28:16] == {3'd5, 5'h07, 5'h15}, "R10", "fields after write", r[28:16], {3'd5, 5'h07, 5'h15});
    chk(r[29] == 1'b0, "R8", "valid clear after write", r[29], 0);

    // R7 read command
    issue(3'd7, 5'h01, 5'h1E, 16'h0001, 16'h0, 16'hBEEF);
    wait_idle(cyc);
    chk(cyc == DUR, "R3", "busy duration read", cyc, DUR);
    bus_read(4'h0, r);
    chk(r[29] == 1'b1, "R7", "read valid set", r[29], 1);
    chk(r[15:0] == 16'hBEEF, "R7", "read data", r[15:0], 16'hBEEF);
    chk(r[28:16] == {3'd7, 5'h1E, 5'h01}, "R10", "fields after read", r[28:16], {3'd7, 5'h1E, 5'h01});

    // R8 valid clears at start; R9 writes during busy ignored
    issue(3'd5, 5'h0A, 5'h03, 16'h4321, 16'hFFFF, 16'h0);
    bus_read(4'h0, r);
    chk(r[29] == 1'b0 && r[30] == 1'b1, "R8", "valid cleared on start", r[30:29], 2'b10);
    bus_write(4'h8, 32'h0000_7777);
    bus_write(4'h0, cmd_word(3'd7, 5'h1F, 5'h1F, 16'h0));
    wait_idle(cyc);
    bus_read(4'h8, r); chk(r == 32'h4321, "R9", "address locked while busy", r, 32'h4321);
    bus_read(4'h0, r);
    chk(r[28:16] == {3'd5, 5'h03, 5'h0A}, "R9", "fields locked while busy", r[28:16], {3'd5, 5'h03, 5'h0A});
    repeat (4 * HALF) @(negedge clk);
    chk(q.size() == 0, "R9", "no extra frames", q.size(), 0);

    // R3 invalid opcode has no effect
    bus_write(4'h0, cmd_word(3'd2, 5'h11, 5'h11, 16'h1111));
    bus_read(4'h0, r);
    chk(r[30] == 1'b0, "R3", "invalid code not busy", r[30], 0);
    chk(r[28:16] == {3'd5, 5'h03, 5'h0A}, "R3", "invalid code fields kept", r[28:16], {3'd5, 5'h03, 5'h0A});
    repeat (8 * HALF) @(negedge clk);
    chk(!mdc && !mdio_oe, "R11", "idle after invalid code", {mdc, mdio_oe}, 0);

    // R7 boundary data patterns
    issue(3'd7, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 16'h0000);
    wait_idle(cyc);
    bus_read(4'h0, r);
    chk(r[29] && r[15:0] == 16'h0000, "R7", "read all zeros", r[29:0], {1'b1, 13'h1FFF | 13'h1C00, 16'h0});
    issue(3'd7, 5'h00, 5'h00, 16'h0000, 16'h0, 16'h8001);
    wait_idle(cyc);
    bus_read(4'h0, r);
    chk(r[29] && r[15:0] == 16'h8001, "R7", "read edge bits", r[15:0], 16'h8001);

    repeat (10) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule